// File: doc/BRIEF.md
# Write-Protected Pin Function Multiplexer

This block owns the pads of a group of I/O ports, eight pins per port. Software programs it over a simple word-wide register bus with per-byte strobes. Each pin is either driven by general-purpose I/O logic or handed to one of up to eight peripheral functions. In GPIO mode a two-bit direction field makes the pin Hi-Z, an input, an output, or an output whose pad level can still be read. In peripheral mode the chosen function drives the pad's output value and output enable. The pad level is passed back to that function only.

The function-select registers sit behind a small protection register. That register holds two bits: a lock bit and a function-write-enable bit. The enable bit can change only while the lock bit is clear, so opening the function-select registers takes two writes, and closing them again takes two more. Pad inputs pass through a two-stage synchronizer before anything inside the block uses them. Read data comes back on the bus one clock after the read is presented.

Top module: `pfm_top`

## Requirements
- R1: After reset every direction field is 0, every mode bit is 0, every function field is 0, every pad output enable is low, and the protection register reads 0x80 (lock set, enable clear).
- R2: Register addresses are byte addresses, and the bus presents aligned 32-bit words with one strobe per byte. For port n, the output-data byte is at 0x10+n, the mode byte at 0x210+n, the 16-bit direction word at 0x120+2n, the 32-bit function word at 0x440+4n, and the input-data byte at 0x810+n. Only strobed bytes are written, and a read returns all stored fields.
- R3: Pin k's direction field sits at bits 2k+1:2k of its port's direction word, encoded as 0 Hi-Z, 1 input, 2 output, 3 output plus input. In GPIO mode the pad output enable equals bit 1 of that field, and the pad output equals the pin's output-data bit.
- R4: Reading the input-data byte returns, per pin, the synchronized pad level when the direction is 1 or 3, the output-data bit when it is 2, and 0 when it is 0.
- R5: A pad input change reaches peripheral inputs and input-data reads through exactly two register stages: it is not visible one clock after the change and is visible after the second.
- R6: The protection register sits at byte 0x3014, with bit 7 as lock and bit 6 as function-write enable. A write always loads the lock from bit 7. It loads the enable from bit 6 only if the lock was 0 before that write; otherwise the enable keeps its value. A read returns both bits in place.
- R7: Writing 0x00 and then 0x40 leaves the enable set, and writing 0x00 and then 0x80 leaves the lock set with the enable clear.
- R8: A write to a function word while the enable is 0 changes nothing, and later reads return the old contents.
- R9: Pin k's function field is the nibble at bits 4k+3:4k of its port's function word. Bits 2:0 pick the function, and bit 3 always reads 0.
- R10: With its mode bit at 1, a pin takes its pad output and output enable from the selected function's output and enable inputs, whatever its direction field holds. Only the selected function's input receives the synchronized pad level; every other function of that pin sees 0.
- R11: With its mode bit at 0, every function input of that pin is 0, whatever the pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address (low two bits ignored) |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, else 0 |
| pad_in | input | NUM_PORTS*8 | Pad levels, asynchronous |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| fn_out | input | NUM_PORTS*8*NUM_FUNCS | Function outputs, index pin*NUM_FUNCS+function |
| fn_oe | input | NUM_PORTS*8*NUM_FUNCS | Function output enables, same indexing |
| fn_in | output | NUM_PORTS*8*NUM_FUNCS | Synchronized pad level to each function, same indexing |

## Verification
The bench targets the protection sequence. It shows that a lone 0x40 written while locked only clears the lock, and that a write with both bits set while locked leaves the enable clear. A design that let the enable follow bit 6 unconditionally would open the function registers in one write. Every read in the bench is compared against its expected value, including the function words after a write that should have been dropped, so a design that accepts locked writes shows changed contents. Input reads use pins in all four direction codes, so returning the pad level for an output pin, or a non-zero value for a Hi-Z pin, gives a wrong byte. The bench steps one clock at a time after a pad change to catch a synchronizer with one stage too few or too many. It checks pad enable and function inputs after mode changes to catch a pin whose direction leaks into peripheral mode, or whose pad level leaks to unselected functions.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    localparam int PINS = 8;
    localparam int FSEL_W = 3;

    localparam int ADR_OUT  = 'h0010;
    localparam int ADR_DIR  = 'h0120;
    localparam int ADR_MODE = 'h0210;
    localparam int ADR_FSEL = 'h0440;
    localparam int ADR_IN   = 'h0810;
    localparam int ADR_WP   = 'h3014;

    localparam int WP_LOCK_BIT = 7;
    localparam int WP_FWE_BIT  = 6;

    typedef enum logic [1:0] {
        DIR_HIZ   = 2'd0,
        DIR_IN    = 2'd1,
        DIR_OUT   = 2'd2,
        DIR_OUTIN = 2'd3
    } dir_e;

    typedef struct packed {
        logic lock;
        logic fwe;
    } wp_regs_t;

    typedef struct packed {
        logic [PINS-1:0]              dout;
        logic [2*PINS-1:0]            dir;
        logic [PINS-1:0]              mode;
        logic [PINS-1:0][FSEL_W-1:0]  fsel;
    } port_regs_t;

endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_regs_t;

    sync_regs_t regs_d, regs_q;

    always_comb begin
        regs_d    = regs_q;
        regs_d.s1 = d;
        regs_d.s2 = regs_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign q = regs_q.s2;

endmodule

// File: rtl/pfm_wprot.sv
module pfm_wprot
    import pfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    output logic       lock,
    output logic       fwe
);

    wp_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d.lock = wbyte[WP_LOCK_BIT];
            // The enable only follows the write while the previous lock is clear.
            if (!regs_q.lock) begin
                regs_d.fwe = wbyte[WP_FWE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{lock: 1'b1, fwe: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign lock = regs_q.lock;
    assign fwe  = regs_q.fwe;

endmodule

// File: rtl/pfm_port.sv
module pfm_port
    import pfm_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int NF       = 8,
    parameter int ADDR_W   = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-3:0]      word,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    input  logic                   fsel_open,
    input  logic [PINS-1:0]        sync_in,
    input  logic [PINS*NF-1:0]     fn_out,
    input  logic [PINS*NF-1:0]     fn_oe,
    output logic [PINS*NF-1:0]     fn_in,
    output logic [PINS-1:0]        pad_out,
    output logic [PINS-1:0]        pad_oe,
    output logic [31:0]            rd_part,
    output logic [PINS-1:0]        mode_o,
    output logic [PINS*FSEL_W-1:0] fsel_o
);

    localparam int WW = ADDR_W - 2;

    localparam int A_OUT  = ADR_OUT + PORT_IDX;
    localparam int A_DIR  = ADR_DIR + 2 * PORT_IDX;
    localparam int A_MODE = ADR_MODE + PORT_IDX;
    localparam int A_FSEL = ADR_FSEL + 4 * PORT_IDX;
    localparam int A_IN   = ADR_IN + PORT_IDX;

    localparam int L_OUT  = A_OUT % 4;
    localparam int L_DIR  = A_DIR % 4;
    localparam int L_MODE = A_MODE % 4;
    localparam int L_IN   = A_IN % 4;

    localparam logic [WW-1:0] W_OUT  = WW'(A_OUT / 4);
    localparam logic [WW-1:0] W_DIR  = WW'(A_DIR / 4);
    localparam logic [WW-1:0] W_MODE = WW'(A_MODE / 4);
    localparam logic [WW-1:0] W_FSEL = WW'(A_FSEL / 4);
    localparam logic [WW-1:0] W_IN   = WW'(A_IN / 4);

    port_regs_t regs_d, regs_q;
    logic [PINS-1:0] in_val;
    logic            unused_wdata;

    assign unused_wdata = ^wdata;

    // Register writes
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (word == W_OUT && be[L_OUT]) begin
                regs_d.dout = wdata[8*L_OUT +: 8];
            end
            if (word == W_DIR) begin
                for (int k = 0; k < 2; k++) begin
                    if (be[L_DIR + k]) begin
                        regs_d.dir[8*k +: 8] = wdata[8*(L_DIR + k) +: 8];
                    end
                end
            end
            if (word == W_MODE && be[L_MODE]) begin
                regs_d.mode = wdata[8*L_MODE +: 8];
            end
            if (word == W_FSEL && fsel_open) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) begin
                        regs_d.fsel[2*b]     = wdata[8*b +: FSEL_W];
                        regs_d.fsel[2*b + 1] = wdata[8*b + 4 +: FSEL_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Pin multiplexing
    always_comb begin
        pad_oe  = '0;
        pad_out = '0;
        fn_in   = '0;
        in_val  = '0;
        for (int i = 0; i < PINS; i++) begin
            if (regs_q.mode[i]) begin
                for (int f = 0; f < NF; f++) begin
                    if (regs_q.fsel[i] == FSEL_W'(f)) begin
                        pad_oe[i]        = fn_oe[i*NF + f];
                        pad_out[i]       = fn_out[i*NF + f];
                        fn_in[i*NF + f]  = sync_in[i];
                    end
                end
            end else begin
                pad_oe[i]  = regs_q.dir[2*i + 1];
                pad_out[i] = regs_q.dout[i];
            end
            if (regs_q.dir[2*i]) begin
                in_val[i] = sync_in[i];
            end else begin
                in_val[i] = regs_q.dir[2*i + 1] & regs_q.dout[i];
            end
        end
    end

    // Read contribution
    always_comb begin
        rd_part = '0;
        if (word == W_OUT) begin
            rd_part[8*L_OUT +: 8] = regs_q.dout;
        end
        if (word == W_DIR) begin
            rd_part[8*L_DIR +: 16] = regs_q.dir;
        end
        if (word == W_MODE) begin
            rd_part[8*L_MODE +: 8] = regs_q.mode;
        end
        if (word == W_FSEL) begin
            for (int i = 0; i < PINS; i++) begin
                rd_part[4*i +: FSEL_W] = regs_q.fsel[i];
            end
        end
        if (word == W_IN) begin
            rd_part[8*L_IN +: 8] = in_val;
        end
    end

    assign mode_o = regs_q.mode;
    assign fsel_o = regs_q.fsel;

endmodule

// File: rtl/pfm_top.sv
module pfm_top
    import pfm_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_FUNCS = 8,
    parameter int ADDR_W    = 14
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_sel,
    input  logic                                 bus_wr,
    input  logic [ADDR_W-1:0]                    bus_addr,
    input  logic [3:0]                           bus_be,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          bus_rdata,
    input  logic [NUM_PORTS*PINS-1:0]            pad_in,
    output logic [NUM_PORTS*PINS-1:0]            pad_out,
    output logic [NUM_PORTS*PINS-1:0]            pad_oe,
    input  logic [NUM_PORTS*PINS*NUM_FUNCS-1:0]  fn_out,
    input  logic [NUM_PORTS*PINS*NUM_FUNCS-1:0]  fn_oe,
    output logic [NUM_PORTS*PINS*NUM_FUNCS-1:0]  fn_in
);

    localparam int NPIN = NUM_PORTS * PINS;
    localparam int PFN  = PINS * NUM_FUNCS;
    localparam int WW   = ADDR_W - 2;
    localparam int L_WP = ADR_WP % 4;
    localparam logic [WW-1:0] W_WP = WW'(ADR_WP / 4);

    typedef struct packed {
        logic [31:0] rdata;
    } top_regs_t;

    top_regs_t regs_d, regs_q;

    logic [WW-1:0]          word;
    logic                   wr_en;
    logic                   rd_en;
    logic                   wp_lock;
    logic                   wp_fwe;
    logic [NPIN-1:0]        sync_q;
    logic [NPIN-1:0]        mode_all;
    logic [NPIN*FSEL_W-1:0] fsel_all;
    logic [31:0]            rd_parts [NUM_PORTS];
    logic                   unused_addr;

    assign word        = bus_addr[ADDR_W-1:2];
    assign wr_en       = bus_sel & bus_wr;
    assign rd_en       = bus_sel & ~bus_wr;
    assign unused_addr = ^bus_addr[1:0];

    pfm_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    pfm_wprot u_wprot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en && word == W_WP && bus_be[L_WP]),
        .wbyte (bus_wdata[8*L_WP +: 8]),
        .lock  (wp_lock),
        .fwe   (wp_fwe)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pfm_port #(
            .PORT_IDX (p),
            .NF       (NUM_FUNCS),
            .ADDR_W   (ADDR_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .word      (word),
            .be        (bus_be),
            .wdata     (bus_wdata),
            .fsel_open (wp_fwe),
            .sync_in   (sync_q[p*PINS +: PINS]),
            .fn_out    (fn_out[p*PFN +: PFN]),
            .fn_oe     (fn_oe[p*PFN +: PFN]),
            .fn_in     (fn_in[p*PFN +: PFN]),
            .pad_out   (pad_out[p*PINS +: PINS]),
            .pad_oe    (pad_oe[p*PINS +: PINS]),
            .rd_part   (rd_parts[p]),
            .mode_o    (mode_all[p*PINS +: PINS]),
            .fsel_o    (fsel_all[p*PINS*FSEL_W +: PINS*FSEL_W])
        );
    end

    always_comb begin
        logic [31:0] merged;
        merged = '0;
        if (word == W_WP) begin
            merged[8*L_WP + WP_LOCK_BIT] = wp_lock;
            merged[8*L_WP + WP_FWE_BIT]  = wp_fwe;
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            merged = merged | rd_parts[p];
        end
        regs_d       = regs_q;
        regs_d.rdata = rd_en ? merged : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;

endmodule

// File: rtl/pfm_checker.sv
module pfm_checker #(
    parameter int NPIN = 16,
    parameter int NF   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NPIN-1:0]    pad_in,
    input logic [NPIN-1:0]    sync_q,
    input logic               wp_lock,
    input logic               wp_fwe,
    input logic [NPIN-1:0]    mode_all,
    input logic [NPIN*3-1:0]  fsel_all,
    input logic [NPIN*NF-1:0] fn_in
);

    logic [1:0] warm_q;
    logic       gpio_leak;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    always_comb begin
        gpio_leak = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            if (!mode_all[i] && (fn_in[i*NF +: NF] != '0)) begin
                gpio_leak = 1'b1;
            end
        end
    end

    assert_fwe_held_when_locked_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        wp_lock |=> $stable(wp_fwe)
    );

    assert_fsel_frozen_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !wp_fwe |=> $stable(fsel_all)
    );

    assert_two_stage_sync_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_q == $past(pad_in, 2))
    );

    assert_gpio_isolated_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        !gpio_leak
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assert_fn_in_single_R10: assert property (
            @(posedge clk) disable iff (!rst_n)
            $onehot0(fn_in[i*NF +: NF])
        );
    end

endmodule

bind pfm_top pfm_checker #(
    .NPIN (NPIN),
    .NF   (NUM_FUNCS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .sync_q   (sync_q),
    .wp_lock  (wp_lock),
    .wp_fwe   (wp_fwe),
    .mode_all (mode_all),
    .fsel_all (fsel_all),
    .fn_in    (fn_in)
);

// File: tb/tb_pfm_top.sv
`timescale 1ns/1ps
module tb_pfm_top;

    localparam int NP   = 2;
    localparam int NF   = 8;
    localparam int AW   = 14;
    localparam int NPIN = NP * 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_sel = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [AW-1:0]        bus_addr = '0;
    logic [3:0]           bus_be = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NPIN-1:0]      pad_in = '0;
    logic [NPIN-1:0]      pad_out;
    logic [NPIN-1:0]      pad_oe;
    logic [NPIN*NF-1:0]   fn_out = '0;
    logic [NPIN*NF-1:0]   fn_oe = '0;
    logic [NPIN*NF-1:0]   fn_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pfm_top #(.NUM_PORTS(NP), .NUM_FUNCS(NF), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int addr, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = AW'(addr);
        bus_be    = be;
        bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
        bus_be  = '0;
    endtask

    // Driver: issue a read and push its expected value for the monitor.
    task automatic bus_read(input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = AW'(addr);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Monitor: a read seen at a rising edge is answered by that edge.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_sel && !bus_wr) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("monitor underflow", bus_rdata, 32'hxxxx_xxxx);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        bus_read('h3014, 32'h0000_0080, "R1 protect reg");
        bus_read('h0120, 32'h0, "R1 direction");
        bus_read('h0210, 32'h0, "R1 mode");
        bus_read('h0440, 32'h0, "R1 function");

        // R2 byte lanes
        bus_write('h0010, 4'b0010, 32'h0000_A500);
        bus_read('h0010, 32'h0000_A500, "R2 out byte port1");
        bus_write('h0010, 4'b0001, 32'hFFFF_FF3C);
        bus_read('h0010, 32'h0000_A53C, "R2 out byte port0");

        // R3 directions: pin0 Hi-Z, pin1 in, pin2 out, pin3 out+in
        bus_write('h0120, 4'b0011, 32'h0000_00E4);
        bus_read('h0120, 32'h0000_00E4, "R2 direction word");
        check("R3 pad_oe gpio", 32'(pad_oe), 32'h0000_000C);
        check("R3 pad_out gpio", 32'(pad_out[7:0]), 32'h0000_003C);

        // R4 input readback
        @(negedge clk);
        pad_in = 16'h00F3;
        repeat (3) @(negedge clk);
        bus_read('h0810, 32'h0000_0006, "R4 input byte");
        bus_write('h0010, 4'b0001, 32'h0);
        bus_read('h0810, 32'h0000_0002, "R4 output pin reads latch");

        // R8 locked function write dropped
        bus_write('h0440, 4'b1111, 32'h0000_0005);
        bus_read('h0440, 32'h0, "R8 locked write dropped");
        // R6 lock bit guards the enable
        bus_write('h3014, 4'b0001, 32'h0000_00C0);
        bus_read('h3014, 32'h0000_0080, "R6 enable held while locked");
        bus_write('h3014, 4'b0001, 32'h0000_0040);
        bus_read('h3014, 32'h0000_0000, "R6 single write only unlocks");
        // R7 unlock
        bus_write('h3014, 4'b0001, 32'h0000_0000);
        bus_write('h3014, 4'b0001, 32'h0000_0040);
        bus_read('h3014, 32'h0000_0040, "R7 unlocked");
        // R9 nibble layout
        bus_write('h0440, 4'b1111, 32'hFFFF_FFFF);
        bus_read('h0440, 32'h7777_7777, "R9 nibble bit3 reads 0");
        bus_write('h0440, 4'b1111, 32'h0000_0025);
        bus_write('h0444, 4'b0001, 32'h0000_00F3);
        bus_read('h0444, 32'h0000_0073, "R9 port1 nibbles");
        // R7 relock
        bus_write('h3014, 4'b0001, 32'h0000_0000);
        bus_read('h3014, 32'h0000_0000, "R7 relock first step");
        bus_write('h3014, 4'b0001, 32'h0000_0080);
        bus_read('h3014, 32'h0000_0080, "R7 relocked");
        bus_write('h0440, 4'b1111, 32'h0000_0001);
        bus_read('h0440, 32'h0000_0025, "R8 dropped after relock");

        // R10 peripheral mode: pin0 -> function 5, pin1 -> function 2
        fn_oe[5]  = 1'b1;
        fn_out[5] = 1'b1;
        fn_oe[10] = 1'b1;
        bus_write('h0210, 4'b0001, 32'h0000_0003);
        bus_read('h0210, 32'h0000_0003, "R2 mode byte");
        check("R10 pad_oe from function", 32'(pad_oe[3:0]), 32'hF);
        check("R10 pad_out from function", 32'(pad_out[1:0]), 32'h1);
        fn_oe[7:0] = 8'hDF;
        @(negedge clk);
        check("R10 unselected enables ignored", 32'(pad_oe[3:0]), 32'hE);
        check("R10 fn_in pin0", 32'(fn_in[7:0]), 32'h20);
        check("R10 fn_in pin1", 32'(fn_in[15:8]), 32'h04);

        // R5 synchronizer depth
        pad_in = 16'h00F2;
        @(negedge clk);
        check("R5 one edge later unchanged", 32'(fn_in[7:0]), 32'h20);
        @(negedge clk);
        check("R5 two edges later updated", 32'(fn_in[7:0]), 32'h00);

        // R11 GPIO pins isolated from functions
        pad_in = 16'h00FF;
        repeat (3) @(negedge clk);
        check("R11 gpio pin2 fn_in", 32'(fn_in[23:16]), 32'h0);
        bus_write('h0210, 4'b0001, 32'h0000_0000);
        check("R11 fn_in after return to gpio", 32'(fn_in[15:0]), 32'h0);
        check("R3 pad_oe after return to gpio", 32'(pad_oe[3:0]), 32'hC);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule